// File: doc/BRIEF.md
# Calibrated Output Coder

This block is the last stage of a conversion channel. It takes one raw 24-bit filter result per valid strobe and produces the final 16-bit output word. It removes the zero-scale calibration value, scales the result by the full-scale calibration value, clamps it to the output range and then encodes it. The encoding is straight binary when the polarity input is high and offset binary when it is low.

The gain coefficient is an unsigned fixed-point number with 22 fractional bits. The product (raw − zero) × gain, which has 22 + 24 fractional bits in total, is shifted right by 30 in unipolar mode. This keeps 16 bits of a 24-bit span. In bipolar mode the product is shifted right by 31, and the midscale code 32768 is added so that the signed span is centred. The coefficients and the polarity bit are captured together with each sample. A later change to any of them therefore never affects a sample that is already in the pipeline. The calibration registers and their reset values (zero-scale 0x1F4000, full-scale 0x5761AB) live outside this block. They are listed in the package only for the block that holds them.

Top module: `cal_out_coder`

## Requirements
- R1: While rst_ni is low and right after reset, valid_o is 0 and code_o is 0x0000.
- R2: Each cycle in which valid_i is high yields exactly one cycle of valid_o high, 3 clock edges later. Back-to-back samples give back-to-back results in the same order.
- R3: When unipolar_i = 1, code_o = ((raw_i − zero_cal_i) × full_cal_i) >> 30, as straight binary, whenever that value lies in 0..65535.
- R4: When unipolar_i = 0, code_o = (((raw_i − zero_cal_i) × full_cal_i) >>> 31) + 32768, as offset binary, whenever that value lies in 0..65535. A raw value equal to zero_cal_i gives 0x8000.
- R5: A scaled value above 65535 (above positive full scale) gives code_o = 0xFFFF in either mode.
- R6: A scaled value below 0 gives code_o = 0x0000 in either mode. In unipolar mode this means any raw value below zero_cal_i.
- R7: The zero_cal_i, full_cal_i and unipolar_i values are taken in the same cycle as the sample they apply to. Changing them in any later cycle does not alter that sample's result.
- R8: code_o holds its last value in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Raw sample strobe |
| raw_i | input | 24 | Raw filter result, unsigned |
| zero_cal_i | input | 24 | Zero-scale (offset) coefficient |
| full_cal_i | input | 24 | Full-scale gain coefficient, 22 fractional bits |
| unipolar_i | input | 1 | 1 = unipolar / straight binary, 0 = bipolar / offset binary |
| valid_o | output | 1 | Result strobe |
| code_o | output | 16 | Calibrated output word |

## Verification
A corrupted difference or product register shows up as a wrong code on the valid_o pulse 3 edges after the affected sample. A lost or extra strobe shows up as a result that arrives in the wrong cycle, or that has no matching input. A polarity bit taken from the wrong stage moves a zero input away from 0x8000, or turns the clamp to 0x0000 into midscale codes. Such faults can be seen on the first result that follows. Coefficient changes made right after a sample, and values at the clamp boundaries, expose a wrong capture point and any off-by-one in the clamp.

// File: rtl/cal_out_pkg.sv
package cal_out_pkg;
  typedef enum logic {POL_BIPOLAR = 1'b0, POL_UNIPOLAR = 1'b1} polarity_e;
  // reset values of the coefficient registers held outside this block
  localparam logic [23:0] ZERO_CAL_RST = 24'h1F4000;
  localparam logic [23:0] FULL_CAL_RST = 24'h5761AB;
endpackage

// File: rtl/cal_diff_stage.sv
module cal_diff_stage
  import cal_out_pkg::*;
#(
  parameter int RAW_W  = 24,
  parameter int COEF_W = 24,
  localparam int DIFF_W = RAW_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [RAW_W-1:0]         raw_i,
  input  logic [RAW_W-1:0]         offset_i,
  input  logic [COEF_W-1:0]        gain_i,
  input  polarity_e                pol_i,
  output logic                     valid_o,
  output logic signed [DIFF_W-1:0] diff_o,
  output logic [COEF_W-1:0]        gain_o,
  output polarity_e                pol_o
);
  // coefficients captured with the sample: later edits cannot reach it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      diff_o  <= '0;
      gain_o  <= '0;
      pol_o   <= POL_BIPOLAR;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        diff_o <= $signed({1'b0, raw_i}) - $signed({1'b0, offset_i});
        gain_o <= gain_i;
        pol_o  <= pol_i;
      end
    end
  end

  AST_CAPTURE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(diff_o) && $stable(gain_o) && $stable(pol_o))); // R7
endmodule

// File: rtl/cal_mult_stage.sv
module cal_mult_stage
  import cal_out_pkg::*;
#(
  parameter int DIFF_W = 25,
  parameter int COEF_W = 24,
  localparam int PROD_W = DIFF_W + COEF_W + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DIFF_W-1:0] diff_i,
  input  logic [COEF_W-1:0]        gain_i,
  input  polarity_e                pol_i,
  output logic                     valid_o,
  output logic signed [PROD_W-1:0] prod_o,
  output polarity_e                pol_o
);
  logic signed [PROD_W-1:0] a_ext, b_ext, prod_d;

  always_comb begin
    a_ext  = PROD_W'(diff_i);
    b_ext  = PROD_W'($signed({1'b0, gain_i}));
    prod_d = a_ext * b_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      prod_o  <= '0;
      pol_o   <= POL_BIPOLAR;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        prod_o <= prod_d;
        pol_o  <= pol_i;
      end
    end
  end

  AST_ZERO_DIFF_ZERO_PROD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && diff_i == '0) |=> (prod_o == '0)); // R4
endmodule

// File: rtl/cal_sat_encode.sv
module cal_sat_encode
  import cal_out_pkg::*;
#(
  parameter int PROD_W  = 50,
  parameter int OUT_W   = 16,
  parameter int SHIFT_U = 30,
  localparam int SHIFT_B = SHIFT_U + 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [PROD_W-1:0] prod_i,
  input  polarity_e                pol_i,
  output logic                     valid_o,
  output logic [OUT_W-1:0]         code_o
);
  localparam logic signed [PROD_W-1:0] FULL_V =
    {{(PROD_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};
  localparam logic signed [PROD_W-1:0] MID_V =
    {{(PROD_W-OUT_W){1'b0}}, 1'b1, {(OUT_W-1){1'b0}}};

  logic signed [PROD_W-1:0] scaled;
  logic [OUT_W-1:0]         code_d;

  always_comb begin
    if (pol_i == POL_UNIPOLAR) scaled = prod_i >>> SHIFT_U;
    else                       scaled = (prod_i >>> SHIFT_B) + MID_V;
    if (scaled < 0)            code_d = '0;
    else if (scaled > FULL_V)  code_d = '1;
    else                       code_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) code_o <= code_d;
    end
  end

  AST_UNI_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pol_i == POL_UNIPOLAR && prod_i < 0) |=> (code_o == '0)); // R6
  AST_BIP_MIDSCALE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pol_i == POL_BIPOLAR && prod_i == '0) |=> (code_o == MID_V[OUT_W-1:0])); // R4
  AST_UNI_CEILING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && pol_i == POL_UNIPOLAR && (prod_i >>> SHIFT_U) > FULL_V) |=> (&code_o)); // R5
endmodule

// File: rtl/cal_out_coder.sv
module cal_out_coder
  import cal_out_pkg::*;
#(
  parameter int RAW_W  = 24,
  parameter int COEF_W = 24,
  parameter int FRAC_W = 22,
  parameter int OUT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [RAW_W-1:0]  raw_i,
  input  logic [RAW_W-1:0]  zero_cal_i,
  input  logic [COEF_W-1:0] full_cal_i,
  input  logic              unipolar_i,
  output logic              valid_o,
  output logic [OUT_W-1:0]  code_o
);
  localparam int DIFF_W  = RAW_W + 1;
  localparam int PROD_W  = DIFF_W + COEF_W + 1;
  localparam int SHIFT_U = FRAC_W + RAW_W - OUT_W;

  logic                     v1, v2;
  logic signed [DIFF_W-1:0] diff_q;
  logic [COEF_W-1:0]        gain_q;
  logic signed [PROD_W-1:0] prod_q;
  polarity_e                pol_in, pol1, pol2;

  assign pol_in = polarity_e'(unipolar_i);

  cal_diff_stage #(.RAW_W(RAW_W), .COEF_W(COEF_W)) u_diff (
    .clk_i, .rst_ni, .valid_i, .raw_i, .offset_i(zero_cal_i), .gain_i(full_cal_i),
    .pol_i(pol_in), .valid_o(v1), .diff_o(diff_q), .gain_o(gain_q), .pol_o(pol1));

  cal_mult_stage #(.DIFF_W(DIFF_W), .COEF_W(COEF_W)) u_mult (
    .clk_i, .rst_ni, .valid_i(v1), .diff_i(diff_q), .gain_i(gain_q), .pol_i(pol1),
    .valid_o(v2), .prod_o(prod_q), .pol_o(pol2));

  cal_sat_encode #(.PROD_W(PROD_W), .OUT_W(OUT_W), .SHIFT_U(SHIFT_U)) u_sat (
    .clk_i, .rst_ni, .valid_i(v2), .prod_i(prod_q), .pol_i(pol2),
    .valid_o, .code_o);

  AST_VALID_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> v1); // R2
  AST_RESULT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2 |=> valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v2 |=> !valid_o); // R2
  AST_CODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(code_o)); // R8
endmodule

// File: tb/sim_cal_out_coder.sv
module sim_cal_out_coder;
  import cal_out_pkg::*;

  typedef struct {
    logic [15:0] code;
    int          due;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [23:0] raw_i = '0, zero_i = '0, full_i = '0;
  logic        uni_i = 1'b0;
  logic        valid_o;
  logic [15:0] code_o;

  int   checks = 0, errors = 0, cyc = 0;
  bit   done = 1'b0, have_last = 1'b0;
  logic [15:0] last_code = '0;
  exp_t q[$];

  localparam logic [23:0] UNITY = 24'h400000;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cal_out_coder u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .raw_i(raw_i),
    .zero_cal_i(zero_i), .full_cal_i(full_i), .unipolar_i(uni_i),
    .valid_o(valid_o), .code_o(code_o));

  function automatic logic [15:0] model(logic [23:0] raw, logic [23:0] off,
                                        logic [23:0] g, logic uni);
    longint d, p, s;
    d = longint'(raw) - longint'(off);
    p = d * longint'(g);
    s = uni ? (p >>> 30) : ((p >>> 31) + 32768);
    if (s < 0) return 16'h0000;
    if (s > 65535) return 16'hFFFF;
    return s[15:0];
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive one sample at a falling edge; valid stays high until idle()
  task automatic send(logic [23:0] raw, logic [23:0] off, logic [23:0] g,
                      logic uni, string tag);
    exp_t e;
    raw_i = raw; zero_i = off; full_i = g; uni_i = uni; valid_i = 1'b1;
    e.code = model(raw, off, g, uni);
    e.due  = cyc + 3;
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // drop valid and disturb the coefficients (R7)
  task automatic idle(int n);
    valid_i = 1'b0;
    raw_i = 24'hA5A5A5; zero_i = 24'h00F00F; full_i = 24'hFFFFFF; uni_i = ~uni_i;
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (valid_o) begin
        if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2: unexpected result %h expected none", code_o);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, 32'(code_o), 32'(e.code));
          check("R2 latency", 32'(cyc), 32'(e.due));
        end
        last_code = code_o;
        have_last = 1'b1;
      end else begin
        check("R8 hold", 32'(code_o), 32'(last_code));
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(valid_o), 32'd0);
    check("R1 code in reset", 32'(code_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 32'(valid_o), 32'd0);
    check("R1 code after reset", 32'(code_o), 32'h0);

    // R3 unipolar straight binary
    send(24'h123456, 24'h000000, UNITY, 1'b1, "R3 unity");
    idle(4);
    send(ZERO_CAL_RST + 24'h100000, ZERO_CAL_RST, FULL_CAL_RST, 1'b1, "R3 default coefs");
    idle(4);
    send(24'hFFFFFF, 24'h000000, UNITY, 1'b1, "R3 top code exact");
    idle(4);
    // R5 above full scale
    send(24'hFFFFFF, 24'h000000, 24'h800000, 1'b1, "R5 unipolar ceiling");
    idle(4);
    send(24'hFFFFFF, 24'h000000, 24'hFFFFFF, 1'b0, "R5 bipolar ceiling");
    idle(4);
    // R6 below zero / negative full scale
    send(24'h0FFFFF, 24'h100000, UNITY, 1'b1, "R6 unipolar below zero");
    idle(4);
    send(24'h000000, 24'hFFFFFF, 24'h800000, 1'b0, "R6 bipolar floor");
    idle(4);
    // R4 bipolar offset binary
    send(ZERO_CAL_RST, ZERO_CAL_RST, FULL_CAL_RST, 1'b0, "R4 zero input midscale");
    idle(4);
    send(24'h400000, 24'h000000, UNITY, 1'b0, "R4 positive half");
    idle(4);
    send(24'h000000, 24'h400000, UNITY, 1'b0, "R4 negative half");
    idle(4);

    // R2 and R7: back-to-back samples, every one with its own coefficients
    for (int i = 0; i < 40; i++) begin
      logic [23:0] r, o, g;
      r = 24'($urandom);
      o = 24'($urandom_range(0, 24'h3FFFFF));
      g = 24'($urandom_range(24'h300000, 24'h600000));
      send(r, o, g, 1'(i % 3 == 0), "R2 R7 burst");
    end
    idle(2);
    for (int i = 0; i < 20; i++) begin
      send(24'($urandom), 24'($urandom), 24'($urandom), 1'($urandom), "R7 sparse");
      idle(1 + (i % 3));
    end

    repeat (8) @(negedge clk);
    check("R2 all results seen", 32'(q.size()), 32'd0);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule